// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI shift engine from the module clock. A 13-bit control word holds two divisor fields and a selector bit. In the linear law the serial clock runs at the module clock divided by 2×(N+1), with N an 8-bit field. In the power law it runs at the module clock divided by 2^N, with N a 4-bit exponent. The block emits a one-cycle tick at every half period of the serial clock. The shift engine uses each tick as its next launch or capture edge. The block also drives a registered serial clock that toggles on every tick.

While the burst enable is low, the serial clock rests at the polarity-selected idle level and no ticks are produced. A start pulse or any change of the control word restarts the half-period count. The first tick after a restart therefore comes exactly one full half period later. Software computes the divisor values. The block only applies them.

Top module: `spi_clk_divider`

## Requirements
- R1: With bit 12 of the control word at 1 (linear law), with N = bits 7:0, ticks are N+1 module clock cycles apart; N=0 gives a tick every cycle (serial clock at half the module clock) and N=255 gives 256 cycles.
- R2: With bit 12 at 0 (power law), with N = bits 11:8, ticks are 2^(N-1) cycles apart for N≥1, and N=0 gives a tick on every cycle.
- R3: Only the field chosen by bit 12 affects the rate; the unselected field is ignored.
- R4: A start pulse sampled at a clock edge clears the tick and returns the serial clock to the idle level at that edge; the first tick follows exactly one half period (in cycles, per R1/R2) of edges later.
- R5: The serial clock output inverts at each edge that raises the tick and holds otherwise.
- R6: While the enable input is low, the serial clock equals the polarity input (0 = idle low, 1 = idle high) and the tick stays low.
- R7: When the control word changes during an enabled burst, the half-period count restarts at that edge without a tick, the serial clock keeps its level, and the next tick follows one new half period later.
- R8: During and directly after synchronous reset, the tick is low and the serial clock equals the polarity input.
- R9: When a start pulse falls on the edge where the count would otherwise end, the restart wins: no tick occurs at that edge, and the next tick comes a full half period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Burst enable; low holds the idle state |
| start_i | input | 1 | One-cycle restart pulse at burst start |
| cpol_i | input | 1 | Idle level of the serial clock |
| ctrl_i | input | 13 | Control word: bit 12 law select, 11:8 exponent, 7:0 linear factor |
| tick_o | output | 1 | One-cycle strobe every serial clock half period |
| sclk_o | output | 1 | Serial clock |

## Verification
Two events can land on the same edge: the counter's natural wrap, which raises a tick and toggles the clock, and a restart caused by a start pulse. The bench waits for a tick at a 4-cycle half period. It counts three further edges so that the counter sits at its last value, then asserts start for the next edge. It then expects no tick at that edge, the clock at its idle level, and the next tick exactly four edges later. A configuration change on a running burst is judged in the same way, except that the clock level must be kept.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;
    parameter int LIN_W  = 8;
    parameter int POW_W  = 4;
    localparam int CTRL_W = LIN_W + POW_W + 1;
    localparam int HALF_W = (1 << POW_W) - 1;   // holds 2^(2^POW_W - 2)

    typedef struct packed {
        logic             lin_sel;
        logic [POW_W-1:0] pow_n;
        logic [LIN_W-1:0] lin_n;
    } div_cfg_t;

    // Half period of the serial clock in module clock cycles.
    function automatic logic [HALF_W-1:0] half_len_f(div_cfg_t c);
        logic [HALF_W-1:0] r;
        if (c.lin_sel) begin
            r = HALF_W'(c.lin_n) + HALF_W'(1);
        end else if (c.pow_n == '0) begin
            r = HALF_W'(1);
        end else begin
            r = HALF_W'(1) << (c.pow_n - POW_W'(1));
        end
        return r;
    endfunction
endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg
    import spi_clk_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [HALF_W-1:0] half_len_o,
    output logic              cfg_change_o
);
    div_cfg_t cfg_now;
    div_cfg_t cfg_prev;

    assign cfg_now = div_cfg_t'(ctrl_i);

    always_ff @(posedge clk) begin
        if (rst) cfg_prev <= '0;
        else     cfg_prev <= cfg_now;
    end

    assign cfg_change_o = (cfg_now != cfg_prev);
    assign half_len_o   = half_len_f(cfg_now);
endmodule

// File: rtl/spi_div_counter.sv
module spi_div_counter
    import spi_clk_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              restart_i,
    input  logic              cfg_change_i,
    input  logic [HALF_W-1:0] half_len_i,
    output logic              wrap_o,
    output logic              tick_o
);
    logic [HALF_W-1:0] cnt;

    assign wrap_o = en_i && !restart_i && (cnt == half_len_i - HALF_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart_i || !en_i) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (wrap_o) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + HALF_W'(1);
            tick_o <= 1'b0;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        !cfg_change_i |-> (cnt < half_len_i)); // R1
endmodule

// File: rtl/spi_div_sclk.sv
module spi_div_sclk (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic start_i,
    input  logic cpol_i,
    input  logic wrap_i,
    output logic sclk_o
);
    always_ff @(posedge clk) begin
        if (rst || !en_i || start_i) sclk_o <= cpol_i;
        else if (wrap_i)             sclk_o <= ~sclk_o;
    end
endmodule

// File: rtl/spi_clk_divider.sv
module spi_clk_divider
    import spi_clk_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              start_i,
    input  logic              cpol_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              tick_o,
    output logic              sclk_o
);
    logic [HALF_W-1:0] half_len;
    logic              cfg_change;
    logic              restart;
    logic              wrap;

    assign restart = start_i || cfg_change;

    spi_div_cfg u_cfg (
        .clk          (clk),
        .rst          (rst),
        .ctrl_i       (ctrl_i),
        .half_len_o   (half_len),
        .cfg_change_o (cfg_change)
    );

    spi_div_counter u_cnt (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en_i),
        .restart_i    (restart),
        .cfg_change_i (cfg_change),
        .half_len_i   (half_len),
        .wrap_o       (wrap),
        .tick_o       (tick_o)
    );

    spi_div_sclk u_sclk (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .start_i (start_i),
        .cpol_i  (cpol_i),
        .wrap_i  (wrap),
        .sclk_o  (sclk_o)
    );

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (sclk_o == $past(cpol_i))); // R6
    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !tick_o); // R6
    AST_START_SILENT: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!tick_o && sclk_o == $past(cpol_i))); // R4
    AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (sclk_o != $past(sclk_o))); // R5
    AST_CFG_RESTART: assert property (@(posedge clk) disable iff (rst)
        (en_i && !start_i && cfg_change) |=> (!tick_o && $stable(sclk_o))); // R7
endmodule

// File: tb/spi_clk_divider_tb.sv
module spi_clk_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        en_i;
    logic        start_i;
    logic        cpol_i;
    logic [12:0] ctrl_i;
    logic        tick_o;
    logic        sclk_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    spi_clk_divider dut_i (
        .clk(clk), .rst(rst), .en_i(en_i), .start_i(start_i),
        .cpol_i(cpol_i), .ctrl_i(ctrl_i), .tick_o(tick_o), .sclk_o(sclk_o)
    );

    // ctrl: bit 12 = 1 linear (N in 7:0), 0 power (N in 11:8)
    localparam int NV = 10;
    localparam logic [12:0] VCTRL [NV] = '{
        13'h1000, 13'h1003, 13'h10FF, 13'h0000, 13'h0100,
        13'h0300, 13'h0500, 13'h0A00, 13'h1702, 13'h03C8 };
    localparam int VEXP [NV] = '{ 1, 4, 256, 1, 1, 4, 16, 512, 3, 4 };
    localparam string VREQ [NV] = '{ "R1", "R1", "R1", "R2", "R2",
                                     "R2", "R2", "R2", "R3", "R3" };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic measure(output int n);
        n = 0;
        for (int k = 0; k < 40000; k++) begin
            step();
            n++;
            if (tick_o) break;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            finish_run();
        end
    end

    initial begin
        int n;
        logic lvl;
        rst = 1'b1; en_i = 1'b0; start_i = 1'b0; cpol_i = 1'b0; ctrl_i = 13'h1000;
        @(negedge clk);
        step(); step();
        check("R8 tick in reset", int'(tick_o), 0);
        check("R8 sclk in reset", int'(sclk_o), 0);
        rst = 1'b0;
        step();
        check("R8 tick after reset", int'(tick_o), 0);
        check("R8 sclk after reset", int'(sclk_o), 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            cpol_i = v[0];
            ctrl_i = VCTRL[v];
            en_i = 1'b1; start_i = 1'b1;
            step();
            start_i = 1'b0;
            check({VREQ[v], " R4 start idle"}, int'(sclk_o), int'(cpol_i));
            check({VREQ[v], " R4 start no tick"}, int'(tick_o), 0);
            measure(n);
            check({VREQ[v], " R4 first half period"}, n, VEXP[v]);
            check({VREQ[v], " R5 first toggle"}, int'(sclk_o), int'(!cpol_i));
            measure(n);
            check({VREQ[v], " second half period"}, n, VEXP[v]);
            check({VREQ[v], " R5 second toggle"}, int'(sclk_o), int'(cpol_i));
        end

        // R6: enable low, both polarities
        en_i = 1'b0; cpol_i = 1'b1; ctrl_i = 13'h1000;
        for (int k = 0; k < 4; k++) begin
            step();
            check("R6 idle high sclk", int'(sclk_o), 1);
            check("R6 idle no tick", int'(tick_o), 0);
        end
        cpol_i = 1'b0;
        step();
        check("R6 idle low sclk", int'(sclk_o), 0);

        // R7: control change mid-burst
        en_i = 1'b1; start_i = 1'b1; ctrl_i = 13'h1001;
        step();
        start_i = 1'b0;
        measure(n);
        check("R7 pre-change period", n, 2);
        step();
        lvl = sclk_o;
        ctrl_i = 13'h1004;
        step();
        check("R7 no tick at change", int'(tick_o), 0);
        check("R7 level kept", int'(sclk_o), int'(lvl));
        measure(n);
        check("R7 new half period", n, 5);

        // R9: start on the wrap edge
        ctrl_i = 13'h1003; start_i = 1'b1;
        step();
        start_i = 1'b0;
        measure(n);
        check("R9 setup period", n, 4);
        step(); step(); step();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        check("R9 no tick on collision", int'(tick_o), 0);
        check("R9 idle after collision", int'(sclk_o), int'(cpol_i));
        measure(n);
        check("R9 full half period after restart", n, 4);

        finish_run();
    end
endmodule